// File: doc/BRIEF.md
# Glitch-Free Dual-Ratio Clock Divider

The block derives two divided clocks from one input clock. Output `q_a` runs at one half or one quarter of the input rate. Output `q_b` runs at one quarter, one fifth or one sixth of the input rate. Both outputs are registered on the rising edge of the input clock and advance together, so any rising edges they share fall on the same input edge.

A synchronous enable is captured on the falling edge of the input clock. The dividers therefore see it change only in the low half of the input period, and no shortened internal clock pulse can occur. While the captured enable is low, both outputs are held low and the phase counters stay frozen. When the enable returns, division resumes from the frozen phase.

An asynchronous master reset clears every flip-flop, so several instances can be brought into step. Ratio selects are sampled only at the start of each output period, so an output never shows a partial period. Select, enable and reset inputs are meant to be tied low when they are not used.

Top module: `clk_div_dual`

## Requirements
- R1: With `sel_a`=0, `q_a` has a period of 2 input cycles (1 high, 1 low). With `sel_a`=1, `q_a` has a period of 4 input cycles (2 high, 2 low).
- R2: `sel_b` selects the ratio of `q_b`. With 00 the period is 4 (2 high, 2 low). With 01 it is 6 (3 high, 3 low). With 10 or 11 it is 5 (2 high, 3 low).
- R3: `rst` is asynchronous and active high. While it is asserted, both outputs are low and all divider state is cleared, including the captured enable.
- R4: After reset, both outputs rise on the same input edge: the first rising edge after the captured enable goes high. Each output period starts with its high phase.
- R5: `en` is captured on the falling edge of `clk`. Outputs change only on rising edges of `clk`, and only a captured value affects them.
- R6: At each rising edge where the captured enable is low, both outputs are driven low and both phase counters hold their value.
- R7: A select value is taken up only at the first rising edge of an output period. A change made in the middle of a period appears at the next period boundary.
- R8: After a disable, division resumes from the frozen phase when the captured enable returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Asynchronous master reset, active high |
| en | input | 1 | Synchronous enable, captured on the falling edge of `clk` |
| sel_a | input | 1 | Ratio select for `q_a` (0: ÷2, 1: ÷4) |
| sel_b | input | 2 | Ratio select for `q_b` (00: ÷4, 01: ÷6, 1x: ÷5) |
| q_a | output | 1 | Divided clock, group A |
| q_b | output | 1 | Divided clock, group B |

## Verification
The embedded assertions check four rules on every cycle. The outputs are low during reset. A low captured enable forces both outputs low on the next cycle. The phase counters hold while disabled. The counters stay inside the longest period. The bench's behavioural model checks the waveform itself: the duty patterns of each ratio, rising edges aligned after reset, selects held back to a period boundary, and resumption from the frozen phase after a disable. These need several cycles of history that no single-cycle property expresses.

// File: rtl/clk_div_dual.sv
module clk_div_dual #(
  parameter int CW = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       sel_a,
  input  logic [1:0] sel_b,
  output logic       q_a,
  output logic       q_b
);

  logic          en_q;
  logic [CW-1:0] ca, cb;
  logic          hold_a;
  logic [1:0]    hold_b;

  // selects are live only on the first edge of a period
  wire           use_a = (ca == '0) ? sel_a : hold_a;
  wire [1:0]     use_b = (cb == '0) ? sel_b : hold_b;
  wire [CW-1:0]  len_a = use_a ? CW'(4) : CW'(2);
  wire [CW-1:0]  hi_a  = len_a >> 1;
  wire [CW-1:0]  len_b = use_b[1] ? CW'(5) : (use_b[0] ? CW'(6) : CW'(4));
  wire [CW-1:0]  hi_b  = (len_b == CW'(6)) ? CW'(3) : CW'(2);

  always_ff @(negedge clk or posedge rst)
    if (rst) en_q <= 1'b0;
    else     en_q <= en;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ca     <= '0;
      cb     <= '0;
      hold_a <= 1'b0;
      hold_b <= 2'b00;
      q_a    <= 1'b0;
      q_b    <= 1'b0;
    end else if (en_q) begin
      if (ca == '0) hold_a <= sel_a;
      if (cb == '0) hold_b <= sel_b;
      ca  <= (ca == len_a - CW'(1)) ? '0 : ca + CW'(1);
      cb  <= (cb == len_b - CW'(1)) ? '0 : cb + CW'(1);
      q_a <= (ca < hi_a);
      q_b <= (cb < hi_b);
    end else begin
      q_a <= 1'b0;
      q_b <= 1'b0;
    end
  end

  a_r3_reset_low: assert property (@(posedge clk) rst |-> (!q_a && !q_b));

  a_r6_disabled_low: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> (!q_a && !q_b));

  a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> ($stable(ca) && $stable(cb)));

  a_r2_phase_bound: assert property (@(posedge clk) disable iff (rst)
    (ca < CW'(4)) && (cb < CW'(6)));

endmodule

// File: tb/clk_div_dual_tb.sv
module clk_div_dual_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic sel_a = 1'b0;
  logic [1:0] sel_b = 2'b00;
  logic q_a, q_b;

  int tests = 0;
  int fails = 0;
  string tag = "R3";

  always #2 clk = ~clk;

  clk_div_dual u_dut (.clk(clk), .rst(rst), .en(en), .sel_a(sel_a),
                      .sel_b(sel_b), .q_a(q_a), .q_b(q_b));

  // behavioural reference
  bit m_en;
  int pa, pb, la, lb;
  bit ea, eb;

  always @(negedge clk or posedge rst)
    if (rst) m_en = 0; else m_en = en;

  always @(posedge clk or posedge rst) begin
    if (rst) begin
      pa = 0; pb = 0; ea = 0; eb = 0; la = 2; lb = 4;
    end else if (m_en) begin
      if (pa == 0) la = sel_a ? 4 : 2;
      if (pb == 0) lb = sel_b[1] ? 5 : (sel_b[0] ? 6 : 4);
      ea = (pa < la / 2);
      eb = (pb < ((lb == 6) ? 3 : 2));
      pa = (pa + 1) % la;
      pb = (pb + 1) % lb;
    end else begin
      ea = 0; eb = 0;
    end
  end

  task automatic check(input string what, input bit act, input bit exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      check("q_a (R1)", q_a, ea);
      check("q_b (R2)", q_b, eb);
    end
  endtask

  initial begin
    fork
      begin
        #3;
        tag = "R3";
        check("reset q_a", q_a, 1'b0);
        check("reset q_b", q_b, 1'b0);
        @(posedge clk); #1;
        rst = 1'b0; en = 1'b1;
        @(posedge clk); #1;
        tag = "R4";
        check("first edge q_a", q_a, 1'b1);
        check("first edge q_b", q_b, 1'b1);
        tag = "R1 R2 R4";
        step(24);
        tag = "R7";
        sel_a = 1'b1; sel_b = 2'b01;
        step(30);
        tag = "R2";
        sel_b = 2'b10;
        step(25);
        sel_b = 2'b11; sel_a = 1'b0;
        step(21);
        tag = "R6 R5";
        en = 1'b0;
        step(9);
        tag = "R8";
        en = 1'b1;
        step(23);
        tag = "R5";
        @(negedge clk); #0.5;
        en = 1'b0;
        @(posedge clk); #0.5;
        en = 1'b1;
        step(12);
        tag = "R3";
        rst = 1'b1; #0.5;
        check("async reset q_a", q_a, 1'b0);
        check("async reset q_b", q_b, 1'b0);
        step(3);
        rst = 1'b0; sel_a = 1'b1; sel_b = 2'b00;
        tag = "R4 R1 R2";
        step(40);
      end
      begin
        #100000;
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule